// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the lowest layer of an I2C master. It carries out one bus primitive at a time on an open-drain two-wire bus: bus recovery, START, STOP, byte write with acknowledge capture, or byte read with acknowledge generation. The host loads a command code together with the byte to send or the acknowledge choice, and pulses a strobe. The engine raises `busy` and steps through a fixed schedule of quarter-bit slots. At the end it drops `busy` and gives a one-cycle `done` pulse.

Every slot lasts `QTR_CYCLES` system clocks, and lines change only at slot boundaries. Both lines are driven only low. A logic one is the line released. The engine reads SDA back through a two-flop synchronizer. Higher layers, such as address framing, transfer length and error policy, are built by sequencing these commands.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, both drive-low outputs are 0 (lines released), `rd_data` is 0x00 and `ack_seen` is 1.
- R2: A strobe with a valid code starts the command and `busy` is 1 from the next cycle. The valid codes are 1 recover, 2 START, 3 STOP, 4 write, 5 read. Codes 0, 6 and 7 are ignored: `busy` stays 0 and the lines do not change.
- R3: A strobe that arrives while `busy` is 1 is ignored. The running schedule is unchanged, and no further command runs after `done`.
- R4: Each slot lasts exactly `QTR_CYCLES` cycles, and the lines change only at slot boundaries. When the last slot ends, `busy` falls and `done` is 1 for exactly one cycle.
- R5: START takes 4 slots. Slot 0 keeps the lines as they are, slot 1 releases SDA, slot 2 releases SCL, and slot 3 pulls SDA low.
- R6: STOP takes 4 slots. Slot 0 pulls SCL low, slot 1 pulls SDA low, slot 2 releases SCL, and slot 3 releases SDA.
- R7: Write sends `wr_byte` MSB first in 4 slots per bit: SCL low, then SDA set to the bit, then SCL released for 2 slots. A ninth clock follows with SDA released, and then one final slot with SCL low, for 37 slots in all.
- R8: For a write, SDA is sampled at the end of the second high slot of the ninth clock. `ack_seen` takes that value: 0 means ACK, 1 means NACK.
- R9: Read keeps SDA released and uses 3 slots per bit: SCL low, then SCL released for 2 slots. It samples SDA at the end of the first high slot and shifts the bits into `rd_data` MSB first.
- R10: After the 8 read bits, the engine gives a ninth clock: SCL low, then SDA driven to the acknowledge, then SCL released for 2 slots, then SCL low. The acknowledge is low when `rd_nack` is 0 and released when it is 1, for 29 slots in all.
- R11: Recovery first releases both lines for one slot. It then gives nine clocks, each 2 slots low and 2 slots high with SDA released, and finishes with the STOP schedule, for 41 slots in all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (see R2) |
| wr_byte | input | 8 | Byte to send for a write |
| rd_nack | input | 1 | Read acknowledge choice: 0 ACK, 1 NACK |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte collected by the last read |
| ack_seen | output | 1 | Acknowledge level sampled by the last write |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
The bench targets the acknowledge-sample instant and the read-sample instant, because the model slave changes SDA only in the slots around them. An engine that samples one slot early or late collects a shifted or inverted byte, or reports the wrong `ack_seen`. It also drives a repeated START straight after a write, when SCL is still low, and a read ACK followed by a read NACK. A design that took the wrong starting line state, or inverted the acknowledge drive, would show a line mismatch in a specific slot. A strobe inside a running command and the unused codes check that the engine neither restarts nor queues work.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  localparam int BYTE_BITS       = 8;
  localparam int RECOVERY_PULSES = 9;
  localparam int WR_QTR_PER_BIT  = 4;
  localparam int RD_QTR_PER_BIT  = 3;
  localparam int QIDX_W          = 6;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_RECOVER = 3'd1,
    CMD_START   = 3'd2,
    CMD_STOP    = 3'd3,
    CMD_WRITE   = 3'd4,
    CMD_READ    = 3'd5
  } cmd_e;

  // One slot's line action: set-enables plus values, and a sample flag.
  typedef struct packed {
    logic scl_en;
    logic scl_lo;
    logic sda_en;
    logic sda_lo;
    logic samp;
  } qstep_t;

  function automatic logic code_valid(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd5);
  endfunction

  function automatic qstep_t stop_step(input int s);
    qstep_t st;
    st = '0;
    case (s)
      0: begin st.scl_en = 1'b1; st.scl_lo = 1'b1; end
      1: begin st.sda_en = 1'b1; st.sda_lo = 1'b1; end
      2: begin st.scl_en = 1'b1; st.scl_lo = 1'b0; end
      default: begin st.sda_en = 1'b1; st.sda_lo = 1'b0; end
    endcase
    return st;
  endfunction

  function automatic logic [QIDX_W-1:0] last_quarter(input cmd_e c);
    case (c)
      CMD_RECOVER: return QIDX_W'(1 + WR_QTR_PER_BIT*RECOVERY_PULSES + 4 - 1);
      CMD_WRITE:   return QIDX_W'(WR_QTR_PER_BIT*(BYTE_BITS+1));
      CMD_READ:    return QIDX_W'(RD_QTR_PER_BIT*BYTE_BITS + 5 - 1);
      default:     return QIDX_W'(3);
    endcase
  endfunction

  function automatic qstep_t plan_quarter(input cmd_e c, input logic [QIDX_W-1:0] q,
                                          input logic [BYTE_BITS-1:0] wbyte,
                                          input logic nack);
    qstep_t st;
    int qi, b, r;
    logic [BYTE_BITS-1:0] sh;
    st = '0;
    qi = int'(q);
    b  = 0;
    r  = 0;
    sh = '0;
    case (c)
      CMD_RECOVER: begin
        if (qi == 0) begin
          st.scl_en = 1'b1; st.sda_en = 1'b1;
        end else if (qi <= WR_QTR_PER_BIT*RECOVERY_PULSES) begin
          r = (qi - 1) % WR_QTR_PER_BIT;
          if (r == 0) begin st.scl_en = 1'b1; st.scl_lo = 1'b1; end
          if (r == 2) begin st.scl_en = 1'b1; st.scl_lo = 1'b0; end
        end else begin
          st = stop_step(qi - WR_QTR_PER_BIT*RECOVERY_PULSES - 1);
        end
      end
      CMD_START: begin
        if (qi == 1) begin st.sda_en = 1'b1; st.sda_lo = 1'b0; end
        if (qi == 2) begin st.scl_en = 1'b1; st.scl_lo = 1'b0; end
        if (qi == 3) begin st.sda_en = 1'b1; st.sda_lo = 1'b1; end
      end
      CMD_STOP: st = stop_step(qi);
      CMD_WRITE: begin
        if (qi < WR_QTR_PER_BIT*(BYTE_BITS+1)) begin
          b  = qi / WR_QTR_PER_BIT;
          r  = qi % WR_QTR_PER_BIT;
          sh = wbyte << b;
          if (r == 0) begin st.scl_en = 1'b1; st.scl_lo = 1'b1; end
          if (r == 1) begin
            st.sda_en = 1'b1;
            st.sda_lo = (b < BYTE_BITS) ? !sh[BYTE_BITS-1] : 1'b0;
          end
          if (r == 2) begin st.scl_en = 1'b1; st.scl_lo = 1'b0; end
          if (r == 3) st.samp = (b == BYTE_BITS);
        end else begin
          st.scl_en = 1'b1; st.scl_lo = 1'b1;
        end
      end
      CMD_READ: begin
        if (qi < RD_QTR_PER_BIT*BYTE_BITS) begin
          r = qi % RD_QTR_PER_BIT;
          if (r == 0) begin
            st.scl_en = 1'b1; st.scl_lo = 1'b1; st.sda_en = 1'b1; st.sda_lo = 1'b0;
          end
          if (r == 1) begin st.scl_en = 1'b1; st.scl_lo = 1'b0; st.samp = 1'b1; end
        end else begin
          r = qi - RD_QTR_PER_BIT*BYTE_BITS;
          if (r == 0 || r == 4) begin st.scl_en = 1'b1; st.scl_lo = 1'b1; end
          if (r == 1) begin st.sda_en = 1'b1; st.sda_lo = !nack; end
          if (r == 2) begin st.scl_en = 1'b1; st.scl_lo = 1'b0; end
        end
      end
      default: st = '0;
    endcase
    return st;
  endfunction

endpackage

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer #(
  parameter int QTR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic qtr_end
);
  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (restart)     cnt <= '0;
    else if (run)         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign qtr_end = run && !restart && (cnt == LAST);

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);
  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_bit_sequencer.sv
module i2c_bit_sequencer
  import i2c_eng_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_code,
  input  logic [BYTE_BITS-1:0] wr_byte,
  input  logic                 rd_nack,
  input  logic                 sda_s,
  input  logic                 qtr_end,
  output logic                 accept,
  output logic                 busy,
  output logic                 done,
  output logic [BYTE_BITS-1:0] rd_data,
  output logic                 ack_seen,
  output logic                 scl_lo,
  output logic                 sda_lo
);
  cmd_e                 cmd_r;
  logic [BYTE_BITS-1:0] byte_r, rd_shift;
  logic                 nack_r, busy_r, done_r, ack_r, scl_lo_r, sda_lo_r;
  logic [QIDX_W-1:0]    q_idx;

  qstep_t step0, step_cur, step_nxt;
  logic   is_last, samp_evt, data_cmd;

  assign accept   = cmd_valid && !busy_r && code_valid(cmd_code);
  assign step0    = plan_quarter(cmd_e'(cmd_code), '0, wr_byte, rd_nack);
  assign step_cur = plan_quarter(cmd_r, q_idx, byte_r, nack_r);
  assign step_nxt = plan_quarter(cmd_r, q_idx + 1'b1, byte_r, nack_r);
  assign is_last  = (q_idx == last_quarter(cmd_r));
  assign samp_evt = busy_r && qtr_end && step_cur.samp;
  assign data_cmd = (cmd_r == CMD_WRITE) || (cmd_r == CMD_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_r    <= CMD_NONE;
      byte_r   <= '0;
      nack_r   <= 1'b0;
      busy_r   <= 1'b0;
      done_r   <= 1'b0;
      ack_r    <= 1'b1;
      rd_shift <= '0;
      q_idx    <= '0;
      scl_lo_r <= 1'b0;
      sda_lo_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (accept) begin
        busy_r <= 1'b1;
        cmd_r  <= cmd_e'(cmd_code);
        byte_r <= wr_byte;
        nack_r <= rd_nack;
        q_idx  <= '0;
        if (step0.scl_en) scl_lo_r <= step0.scl_lo;
        if (step0.sda_en) sda_lo_r <= step0.sda_lo;
      end else if (busy_r && qtr_end) begin
        if (samp_evt) begin
          if (cmd_r == CMD_WRITE) ack_r    <= sda_s;
          else                    rd_shift <= {rd_shift[BYTE_BITS-2:0], sda_s};
        end
        if (is_last) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end else begin
          q_idx <= q_idx + 1'b1;
          if (step_nxt.scl_en) scl_lo_r <= step_nxt.scl_lo;
          if (step_nxt.sda_en) sda_lo_r <= step_nxt.sda_lo;
        end
      end
    end
  end

  assign busy     = busy_r;
  assign done     = done_r;
  assign rd_data  = rd_shift;
  assign ack_seen = ack_r;
  assign scl_lo   = scl_lo_r;
  assign sda_lo   = sda_lo_r;

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_lines_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !qtr_end) |=> $stable({scl_lo_r, sda_lo_r}));
  assert_busy_strobe_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (cmd_r == $past(cmd_r)));
  assert_sample_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    samp_evt |-> !scl_lo_r);
  assert_data_sda_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_cmd && !scl_lo_r) |=> (sda_lo_r == $past(sda_lo_r)));

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_eng_pkg::*;
#(
  parameter int QTR_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic [7:0] wr_byte,
  input  logic       rd_nack,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       ack_seen,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low
);
  logic       accept, qtr_end;
  logic [1:0] lines_s;

  i2c_qtr_timer #(.QTR_CYCLES(QTR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy), .qtr_end(qtr_end)
  );

  i2c_line_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(lines_s)
  );

  i2c_bit_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_byte(wr_byte), .rd_nack(rd_nack), .sda_s(lines_s[0]), .qtr_end(qtr_end),
    .accept(accept), .busy(busy), .done(done), .rd_data(rd_data),
    .ack_seen(ack_seen), .scl_lo(scl_drive_low), .sda_lo(sda_drive_low)
  );

  assert_accept_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

endmodule

// File: tb/test_i2c_bit_engine.sv
module test_i2c_bit_engine;
  localparam int QTR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [7:0] wr_byte = 8'h00;
  logic rd_nack = 1'b0;
  logic slv_pull = 1'b0;
  logic busy, done, ack_seen, scl_drive_low, sda_drive_low, scl_in, sda_in;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit cur_scl = 0, cur_sda = 0;
  bit qscl[$], qsda[$], qpull[$];

  always #4 clk = ~clk;

  assign scl_in = !scl_drive_low;
  assign sda_in = !(sda_drive_low || slv_pull);

  i2c_bit_engine #(.QTR_CYCLES(QTR)) i_i2c_bit_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_byte(wr_byte), .rd_nack(rd_nack), .busy(busy), .done(done),
    .rd_data(rd_data), .ack_seen(ack_seen), .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic put(input bit s, input bit d, input bit p);
    qscl.push_back(s); qsda.push_back(d); qpull.push_back(p);
    cur_scl = s; cur_sda = d;
  endtask

  task automatic plan_stop();
    put(1, cur_sda, 0); put(1, 1, 0); put(0, 1, 0); put(0, 0, 0);
  endtask

  // Expected slot list, written from the requirements (1 = line pulled low).
  task automatic plan(input int code, input logic [7:0] wb, input bit nk,
                      input bit sack, input logic [7:0] rb);
    qscl.delete(); qsda.delete(); qpull.delete();
    case (code)
      1: begin
        put(0, 0, 0);
        repeat (9) begin put(1, 0, 0); put(1, 0, 0); put(0, 0, 0); put(0, 0, 0); end
        plan_stop();
      end
      2: begin put(cur_scl, cur_sda, 0); put(cur_scl, 0, 0); put(0, 0, 0); put(0, 1, 0); end
      3: plan_stop();
      4: begin
        for (int b = 7; b >= 0; b--) begin
          put(1, cur_sda, 0); put(1, !wb[b], 0); put(0, !wb[b], 0); put(0, !wb[b], 0);
        end
        put(1, cur_sda, 0); put(1, 0, sack); put(0, 0, sack); put(0, 0, sack); put(1, 0, 0);
      end
      default: begin
        for (int b = 7; b >= 0; b--) begin
          put(1, 0, !rb[b]); put(0, 0, !rb[b]); put(0, 0, !rb[b]);
        end
        put(1, 0, 0); put(1, !nk, 0); put(0, !nk, 0); put(0, !nk, 0); put(1, !nk, 0);
      end
    endcase
  endtask

  task automatic run_cmd(input int code, input logic [7:0] wb, input bit nk,
                         input bit sack, input logic [7:0] rb, input bit poke,
                         input string tag);
    int nq;
    plan(code, wb, nk, sack, rb);
    nq = qscl.size();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'(code); wr_byte = wb; rd_nack = nk;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < nq*QTR; k++) begin
      slv_pull = qpull[k/QTR];
      if (poke && k == 5) begin cmd_valid = 1'b1; cmd_code = 3'd3; wr_byte = 8'hFF; end
      else cmd_valid = 1'b0;
      chk(tag, "scl_drive_low", 32'(scl_drive_low), 32'(qscl[k/QTR]));
      chk(tag, "sda_drive_low", 32'(sda_drive_low), 32'(qsda[k/QTR]));
      chk("R4", "busy during command", 32'(busy), 32'd1);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    slv_pull = 1'b0;
    chk("R4", "done at end", 32'(done), 32'd1);
    chk("R4", "busy at end", 32'(busy), 32'd0);
    chk(tag, "final scl", 32'(scl_drive_low), 32'(cur_scl));
    chk(tag, "final sda", 32'(sda_drive_low), 32'(cur_sda));
    if (code == 4) chk("R8", "ack_seen", 32'(ack_seen), 32'(!sack));
    if (code == 5) chk("R9", "rd_data", 32'(rd_data), 32'(rb));
    @(negedge clk);
    chk("R4", "done one cycle", 32'(done), 32'd0);
    chk("R3", "no queued command", 32'(busy), 32'd0);
  endtask

  task automatic try_bad_code(input logic [2:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) begin
      chk("R2", "busy after unused code", 32'(busy), 32'd0);
      chk("R2", "scl after unused code", 32'(scl_drive_low), 32'(cur_scl));
      chk("R2", "sda after unused code", 32'(sda_drive_low), 32'(cur_sda));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "scl", 32'(scl_drive_low), 32'd0);
    chk("R1", "sda", 32'(sda_drive_low), 32'd0);
    chk("R1", "rd_data", 32'(rd_data), 32'h00);
    chk("R1", "ack_seen", 32'(ack_seen), 32'd1);
    try_bad_code(3'd0);
    run_cmd(2, 8'h00, 0, 0, 8'h00, 0, "R5");
    run_cmd(4, 8'hA5, 0, 1, 8'h00, 1, "R7");
    run_cmd(4, 8'h3C, 0, 0, 8'h00, 0, "R7");
    run_cmd(2, 8'h00, 0, 0, 8'h00, 0, "R5");
    run_cmd(5, 8'h00, 0, 0, 8'h96, 0, "R9");
    run_cmd(5, 8'h00, 1, 0, 8'h5A, 0, "R10");
    run_cmd(3, 8'h00, 0, 0, 8'h00, 0, "R6");
    try_bad_code(3'd6);
    try_bad_code(3'd7);
    run_cmd(1, 8'h00, 0, 0, 8'h00, 0, "R11");
    run_cmd(4, 8'h01, 0, 1, 8'h00, 0, "R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule